// File: doc/BRIEF.md
# Synchronous Conversion Chain Sequencer

This block steps two converter front ends through programmable conversion chains. Each chain has one to eight segments. Every segment names the input channel to convert and carries three flags: one raises an interrupt pulse when its result arrives, one is forwarded to the converter as a hardware-select tag, and one lets the following segment start at once instead of waiting for the next trigger. A trigger starts the chain at segment 0. Each conversion request is a single-cycle pulse that carries the segment's channel. The sequencer then waits for the converter's done strobe and stores the 12-bit result in that segment's 16-bit result slot.

The secondary chain can be locked to the primary chain. In sync mode it ignores its own trigger and starts on the primary trigger in the same cycle. Results are read as 32-bit words, each holding two adjacent segments. When a chain finishes, an enabled DMA request is raised. It is either a one-cycle pulse or a level that stays high until software reads the first result word of that chain. A trigger that arrives while a conversion is in flight is rejected and recorded in a sticky overrun flag. A soft-reset level returns everything to idle.

Top module: `chain_seq`

## Requirements
- R1: The chain-length input holds the segment count minus one (0 to 7). A chain issues exactly that many plus one conversion requests, then returns to idle (busy low).
- R2: A conversion request is high for one cycle. It carries the channel select from bits [3:0] and the hardware-select flag from bit 5 of the active segment's 7-bit configuration field. Segment s occupies bits [7s+6:7s] of the configuration input.
- R3: If bit 6 (back-to-back) of segment s is set, segment s+1 is requested in the cycle after segment s's done strobe. If the bit is clear, the chain holds and segment s+1 starts only on the next trigger. A trigger that arrives while the chain holds is not an overrun.
- R4: When syncMode is 1, the secondary chain ignores trigSec and issues its first request in the same cycle as the primary chain, on trigPri. When syncMode is 0, trigPri does not start the secondary chain and trigSec does not start the primary chain.
- R5: Result word p of a chain is {segment 2p+1, segment 2p}. Each half is the 12-bit conversion result zero-extended to 16 bits. rdSec selects the chain (0 primary, 1 secondary) and rdPair selects p.
- R6: With dmaHold at 0, an enabled chain raises its DMA request for exactly one cycle per completed chain. With the chain's DMA enable at 0, no request is raised.
- R7: With dmaHold at 1, the DMA request rises at chain completion. It stays high until a cycle with rdEn high, rdPair 0 and rdSec selecting that chain. Reading any other word leaves it high.
- R8: A trigger that arrives while a request is pending or a conversion is in flight does not restart the chain. It sets that chain's overrun flag, which stays set until soft reset.
- R9: While softRst is high, both chains are idle, triggers are ignored, and the overrun flags, DMA requests and all result slots are cleared. After reset the outputs are all zero.
- R10: A segment whose bit 4 (interrupt enable) is set produces one single-cycle interrupt pulse after its result is captured. Other segments produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Soft reset level, holds block idle |
| syncMode | input | 1 | Lock secondary chain to primary trigger |
| trigPri | input | 1 | Primary trigger pulse |
| trigSec | input | 1 | Secondary trigger pulse |
| lenPri | input | 3 | Primary segment count minus one |
| lenSec | input | 3 | Secondary segment count minus one |
| cfgPri | input | 56 | Primary segment configuration, 7 bits per segment |
| cfgSec | input | 56 | Secondary segment configuration, 7 bits per segment |
| dmaEnPri | input | 1 | Primary DMA request enable |
| dmaEnSec | input | 1 | Secondary DMA request enable |
| dmaHold | input | 1 | 1: level request cleared by read, 0: pulse |
| convReqPri | output | 1 | Primary conversion request |
| convChanPri | output | 4 | Primary channel select |
| convHwPri | output | 1 | Primary hardware-select tag |
| convDonePri | input | 1 | Primary conversion done strobe |
| convDataPri | input | 12 | Primary conversion result |
| convReqSec | output | 1 | Secondary conversion request |
| convChanSec | output | 4 | Secondary channel select |
| convHwSec | output | 1 | Secondary hardware-select tag |
| convDoneSec | input | 1 | Secondary conversion done strobe |
| convDataSec | input | 12 | Secondary conversion result |
| irqPri | output | 1 | Primary segment interrupt pulse |
| irqSec | output | 1 | Secondary segment interrupt pulse |
| ovrPri | output | 1 | Primary sticky overrun |
| ovrSec | output | 1 | Secondary sticky overrun |
| busyPri | output | 1 | Primary chain not idle |
| busySec | output | 1 | Secondary chain not idle |
| rdEn | input | 1 | Result read strobe |
| rdSec | input | 1 | Chain select for reads |
| rdPair | input | 2 | Result word index |
| rdData | output | 32 | Selected result word |
| dmaReqPri | output | 1 | Primary DMA request |
| dmaReqSec | output | 1 | Secondary DMA request |

## Verification
The bench goes after the segment-count encoding at lengths 1, 2, 4 and 8. A design off by one would issue one request too many or too few, and would leave an upper half-word filled or empty. It measures the gap between a done strobe and the next request to catch a back-to-back chain that waits a cycle too long, and it checks that a chain without back-to-back stalls until the next trigger. The remaining targets are a second trigger during a running chain, which a wrong design would use to restart the chain or would fail to flag, and the read that clears a held DMA request, which a wrong design would accept on any word. In sync mode it checks that both chains start in the same cycle and that trigSec alone starts nothing.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;
  localparam int MAX_SEG = 8;
  localparam int SEG_IDX_W = $clog2(MAX_SEG);
  localparam int CHAN_W = 4;

  // One segment's settings, MSB first: back-to-back, hw select, irq enable, channel
  typedef struct packed {
    logic b2b;
    logic hwSel;
    logic irqEn;
    logic [CHAN_W-1:0] chan;
  } segCfg_t;

  localparam int SEG_CFG_W = $bits(segCfg_t);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_HOLD
  } chainState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;
    logic [SEG_IDX_W-1:0] segIdx;
    logic chainDone;
  } seqStrobe_t;
endpackage

// File: rtl/chain_seq_ctrl.sv
module chain_seq_ctrl
  import chain_seq_pkg::*;
#(
  parameter int SEGS = MAX_SEG,
  localparam int SW = $clog2(SEGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  softRst,
  input  logic                  trig,
  input  logic [SW-1:0]         lenM1,
  input  segCfg_t [SEGS-1:0]    cfg,
  input  logic                  convDone,
  output logic                  convReq,
  output logic [CHAN_W-1:0]     convChan,
  output logic                  convHw,
  output logic                  busy,
  output logic                  overrun,
  output logic                  irq,
  output seqStrobe_t            stb
);
  chainState_t state;
  logic [SW-1:0] seg;
  segCfg_t cur;
  logic capture;
  logic lastSeg;
  logic inFlight;

  assign cur      = cfg[seg];
  assign lastSeg  = (seg == lenM1);
  assign inFlight = (state == ST_REQ) || (state == ST_WAIT);
  assign capture  = (state == ST_WAIT) && convDone && !softRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      seg     <= '0;
      overrun <= 1'b0;
      irq     <= 1'b0;
    end else if (softRst) begin
      state   <= ST_IDLE;
      seg     <= '0;
      overrun <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= capture && cur.irqEn;
      if (trig && inFlight) overrun <= 1'b1;
      case (state)
        ST_IDLE: begin
          seg <= '0;
          if (trig) state <= ST_REQ;
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: begin
          if (convDone) begin
            if (lastSeg) begin
              state <= ST_IDLE;
              seg   <= '0;
            end else begin
              seg   <= seg + 1'b1;
              state <= cur.b2b ? ST_REQ : ST_HOLD;
            end
          end
        end
        ST_HOLD: if (trig) state <= ST_REQ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign convReq       = (state == ST_REQ);
  assign convChan      = cur.chan;
  assign convHw        = cur.hwSel;
  assign busy          = (state != ST_IDLE);
  assign stb.capture   = capture;
  assign stb.segIdx    = SEG_IDX_W'(seg);
  assign stb.chainDone = capture && lastSeg;
endmodule

// File: rtl/chain_seq_datapath.sv
module chain_seq_datapath
  import chain_seq_pkg::*;
#(
  parameter int SEGS   = MAX_SEG,
  parameter int DATA_W = 12,
  parameter int RES_W  = 16,
  parameter int NCH    = 2,
  localparam int PAIRS  = SEGS / 2,
  localparam int PAIR_W = $clog2(PAIRS),
  localparam int WORD_W = 2 * RES_W,
  localparam int CSEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        softRst,
  input  seqStrobe_t [NCH-1:0]        stb,
  input  logic [NCH-1:0][DATA_W-1:0]  convData,
  input  logic [NCH-1:0]              dmaEn,
  input  logic                        dmaHold,
  input  logic                        rdEn,
  input  logic [CSEL_W-1:0]           rdSel,
  input  logic [PAIR_W-1:0]           rdPair,
  output logic [WORD_W-1:0]           rdData,
  output logic [NCH-1:0]              dmaReq
);
  logic [NCH-1:0][SEGS*RES_W-1:0] bankAll;

  for (genvar c = 0; c < NCH; c++) begin : g_chain
    logic [SEGS*RES_W-1:0] bank;
    logic dmaQ;
    logic clrRead;

    assign clrRead = rdEn && (rdSel == CSEL_W'(c)) && (rdPair == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bank <= '0;
      end else if (softRst) begin
        bank <= '0;
      end else if (stb[c].capture) begin
        bank[stb[c].segIdx*RES_W +: RES_W] <= RES_W'(convData[c]);
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dmaQ <= 1'b0;
      end else if (softRst) begin
        dmaQ <= 1'b0;
      end else if (dmaHold) begin
        if (stb[c].chainDone && dmaEn[c]) dmaQ <= 1'b1;
        else if (clrRead)                 dmaQ <= 1'b0;
      end else begin
        dmaQ <= stb[c].chainDone && dmaEn[c];
      end
    end

    assign bankAll[c] = bank;
    assign dmaReq[c]  = dmaQ;
  end

  assign rdData = bankAll[rdSel][rdPair*WORD_W +: WORD_W];
endmodule

// File: rtl/chain_seq.sv
module chain_seq
  import chain_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        syncMode,
  input  logic        trigPri,
  input  logic        trigSec,
  input  logic [2:0]  lenPri,
  input  logic [2:0]  lenSec,
  input  logic [55:0] cfgPri,
  input  logic [55:0] cfgSec,
  input  logic        dmaEnPri,
  input  logic        dmaEnSec,
  input  logic        dmaHold,
  output logic        convReqPri,
  output logic [3:0]  convChanPri,
  output logic        convHwPri,
  input  logic        convDonePri,
  input  logic [11:0] convDataPri,
  output logic        convReqSec,
  output logic [3:0]  convChanSec,
  output logic        convHwSec,
  input  logic        convDoneSec,
  input  logic [11:0] convDataSec,
  output logic        irqPri,
  output logic        irqSec,
  output logic        ovrPri,
  output logic        ovrSec,
  output logic        busyPri,
  output logic        busySec,
  input  logic        rdEn,
  input  logic        rdSec,
  input  logic [1:0]  rdPair,
  output logic [31:0] rdData,
  output logic        dmaReqPri,
  output logic        dmaReqSec
);
  localparam int NCH = 2;
  localparam int SEGS = MAX_SEG;

  logic [NCH-1:0]              trigEff;
  logic [NCH-1:0][2:0]         lenAll;
  segCfg_t [NCH-1:0][SEGS-1:0] cfgAll;
  logic [NCH-1:0]              doneAll;
  logic [NCH-1:0][11:0]        dataAll;
  logic [NCH-1:0]              reqAll, hwAll, busyAll, ovrAll, irqAll, dmaAll;
  logic [NCH-1:0][CHAN_W-1:0]  chanAll;
  seqStrobe_t [NCH-1:0]        stbAll;

  // The secondary chain follows the primary trigger in sync mode
  assign trigEff[0] = trigPri;
  assign trigEff[1] = syncMode ? trigPri : trigSec;
  assign lenAll     = {lenSec, lenPri};
  assign cfgAll     = {cfgSec, cfgPri};
  assign doneAll    = {convDoneSec, convDonePri};
  assign dataAll    = {convDataSec, convDataPri};

  for (genvar c = 0; c < NCH; c++) begin : g_ctrl
    chain_seq_ctrl #(.SEGS(SEGS)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .softRst  (softRst),
      .trig     (trigEff[c]),
      .lenM1    (lenAll[c]),
      .cfg      (cfgAll[c]),
      .convDone (doneAll[c]),
      .convReq  (reqAll[c]),
      .convChan (chanAll[c]),
      .convHw   (hwAll[c]),
      .busy     (busyAll[c]),
      .overrun  (ovrAll[c]),
      .irq      (irqAll[c]),
      .stb      (stbAll[c])
    );
  end

  chain_seq_datapath #(.SEGS(SEGS), .DATA_W(12), .RES_W(16), .NCH(NCH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .softRst  (softRst),
    .stb      (stbAll),
    .convData (dataAll),
    .dmaEn    ({dmaEnSec, dmaEnPri}),
    .dmaHold  (dmaHold),
    .rdEn     (rdEn),
    .rdSel    (rdSec),
    .rdPair   (rdPair),
    .rdData   (rdData),
    .dmaReq   (dmaAll)
  );

  assign convReqPri  = reqAll[0];
  assign convChanPri = chanAll[0];
  assign convHwPri   = hwAll[0];
  assign convReqSec  = reqAll[1];
  assign convChanSec = chanAll[1];
  assign convHwSec   = hwAll[1];
  assign irqPri      = irqAll[0];
  assign irqSec      = irqAll[1];
  assign ovrPri      = ovrAll[0];
  assign ovrSec      = ovrAll[1];
  assign busyPri     = busyAll[0];
  assign busySec     = busyAll[1];
  assign dmaReqPri   = dmaAll[0];
  assign dmaReqSec   = dmaAll[1];
endmodule

// File: rtl/chain_seq_chk.sv
module chain_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       softRst,
  input logic       syncMode,
  input logic       trigPri,
  input logic       dmaHold,
  input logic       convReqPri,
  input logic       convReqSec,
  input logic       irqPri,
  input logic       ovrPri,
  input logic       ovrSec,
  input logic       busyPri,
  input logic       busySec,
  input logic       rdEn,
  input logic       rdSec,
  input logic [1:0] rdPair,
  input logic       dmaReqPri,
  input logic       dmaReqSec
);
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    convReqPri |=> !convReqPri);

  assert_sync_start_R4: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (syncMode && trigPri && !busyPri && !busySec) |=> (convReqPri && convReqSec));

  assert_dma_pulse_R6: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (!dmaHold && dmaReqPri) |=> !dmaReqPri);

  assert_dma_hold_R7: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (dmaHold && dmaReqPri && !(rdEn && !rdSec && rdPair == 2'd0)) |=> (dmaReqPri || !dmaHold));

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (ovrPri || ovrSec) |=> (ovrPri || ovrSec));

  assert_soft_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!busyPri && !busySec && !ovrPri && !ovrSec && !dmaReqPri && !dmaReqSec));

  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqPri |=> !irqPri);
endmodule

bind chain_seq chain_seq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .softRst    (softRst),
  .syncMode   (syncMode),
  .trigPri    (trigPri),
  .dmaHold    (dmaHold),
  .convReqPri (convReqPri),
  .convReqSec (convReqSec),
  .irqPri     (irqPri),
  .ovrPri     (ovrPri),
  .ovrSec     (ovrSec),
  .busyPri    (busyPri),
  .busySec    (busySec),
  .rdEn       (rdEn),
  .rdSec      (rdSec),
  .rdPair     (rdPair),
  .dmaReqPri  (dmaReqPri),
  .dmaReqSec  (dmaReqSec)
);

// File: tb/chain_seq_tb.sv
module chain_seq_tb;
  localparam int LAT = 3;
  localparam int WDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0, syncMode = 1'b0, trigPri = 1'b0, trigSec = 1'b0;
  logic [2:0] lenPri = '0, lenSec = '0;
  logic [55:0] cfgPri = '0, cfgSec = '0;
  logic dmaEnPri = 1'b1, dmaEnSec = 1'b1, dmaHold = 1'b0;
  logic convReqPri, convHwPri, convReqSec, convHwSec;
  logic [3:0] convChanPri, convChanSec;
  logic convDonePri, convDoneSec;
  logic [11:0] convDataPri, convDataSec;
  logic irqPri, irqSec, ovrPri, ovrSec, busyPri, busySec;
  logic rdEn = 1'b0, rdSec = 1'b0;
  logic [1:0] rdPair = '0;
  logic [31:0] rdData;
  logic dmaReqPri, dmaReqSec;

  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  chain_seq u_dut (.*);

  // Converter models with fixed latency
  logic [LAT-1:0] pipeP = '0, pipeS = '0;
  logic [3:0] chP [LAT];
  logic [3:0] chS [LAT];
  always @(posedge clk) begin
    pipeP <= {pipeP[LAT-2:0], convReqPri};
    pipeS <= {pipeS[LAT-2:0], convReqSec};
    chP[0] <= convChanPri;
    chS[0] <= convChanSec;
    for (int i = 1; i < LAT; i++) begin
      chP[i] <= chP[i-1];
      chS[i] <= chS[i-1];
    end
  end
  assign convDonePri = pipeP[LAT-1];
  assign convDoneSec = pipeS[LAT-1];
  assign convDataPri = {chP[LAT-1], 8'hA5};
  assign convDataSec = {chS[LAT-1], 8'h3C};

  function automatic logic [15:0] expRes(input logic sec, input logic [3:0] ch);
    return {4'h0, ch, (sec ? 8'h3C : 8'hA5)};
  endfunction

  // Monitors, sampled at the falling edge
  int reqP = 0, reqS = 0, doneP = 0, irqP = 0, dmaP = 0;
  int reqCycP [1024];
  int reqCycS [1024];
  int doneCycP [1024];
  logic [3:0] chanLogP [1024];
  logic hwLogP [1024];
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (convReqPri) begin
      reqCycP[reqP % 1024] <= cyc;
      chanLogP[reqP % 1024] <= convChanPri;
      hwLogP[reqP % 1024] <= convHwPri;
      reqP <= reqP + 1;
    end
    if (convReqSec) begin
      reqCycS[reqS % 1024] <= cyc;
      reqS <= reqS + 1;
    end
    if (convDonePri) begin
      doneCycP[doneP % 1024] <= cyc;
      doneP <= doneP + 1;
    end
    if (irqPri) irqP <= irqP + 1;
    if (dmaReqPri) dmaP <= dmaP + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulsePri();
    @(negedge clk) trigPri = 1'b1;
    @(negedge clk) trigPri = 1'b0;
  endtask

  task automatic pulseSec();
    @(negedge clk) trigSec = 1'b1;
    @(negedge clk) trigSec = 1'b0;
  endtask

  task automatic doSoft();
    @(negedge clk) softRst = 1'b1;
    waitCyc(2);
    softRst = 1'b0;
    waitCyc(LAT + 2);
  endtask

  task automatic readWord(input logic sec, input logic [1:0] p, output logic [31:0] w);
    rdSec = sec;
    rdPair = p;
    #1 w = rdData;
  endtask

  function automatic logic [55:0] mkCfg(input logic [3:0] base, input logic [7:0] b2b,
                                        input logic [7:0] ie, input logic [7:0] hw);
    logic [55:0] v;
    for (int s = 0; s < 8; s++) v[7*s +: 7] = {b2b[s], hw[s], ie[s], 4'(base + s)};
    return v;
  endfunction

  // Stimulus table: {segment count minus one, base channel}
  localparam logic [6:0] VEC [6] = '{
    {3'd0, 4'd2}, {3'd1, 4'd5}, {3'd3, 4'd12},
    {3'd7, 4'd0}, {3'd7, 4'd9}, {3'd3, 4'd1}
  };

  initial begin : watchdog
    wait (cyc == WDOG);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] w;
    int r0, d0, i0, m0, s0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    // Reset state
    chk("R9 reset busy/ovr/dma", {busyPri, busySec, ovrPri, ovrSec, dmaReqPri, dmaReqSec, convReqPri, convReqSec}, '0);
    readWord(1'b0, 2'd0, w);
    chk("R9 reset result", w, '0);

    // Table-driven chains, all back-to-back, pulse DMA
    for (int v = 0; v < 6; v++) begin
      logic [2:0] len;
      logic [3:0] base;
      int nIe;
      {len, base} = VEC[v];
      doSoft();
      cfgPri = mkCfg(base, 8'hFF, 8'h55, 8'h0F);
      lenPri = len;
      r0 = reqP; d0 = doneP; i0 = irqP; m0 = dmaP;
      pulsePri();
      waitCyc(60);
      chk("R1 request count", reqP - r0, int'(len) + 1);
      chk("R1 idle after chain", busyPri, 1'b0);
      nIe = 0;
      for (int s = 0; s <= int'(len); s++) begin
        chk("R2 channel per segment", chanLogP[(r0 + s) % 1024], 4'(base + s));
        chk("R2 hw select per segment", hwLogP[(r0 + s) % 1024], (s < 4));
        if (s > 0) chk("R3 back-to-back gap", reqCycP[(r0 + s) % 1024] - doneCycP[(d0 + s - 1) % 1024], 1);
        if (s % 2 == 0) nIe++;
      end
      for (int p = 0; p < 4; p++) begin
        logic [15:0] lo, hi;
        lo = (2*p <= int'(len)) ? expRes(1'b0, 4'(base + 2*p)) : 16'h0;
        hi = (2*p + 1 <= int'(len)) ? expRes(1'b0, 4'(base + 2*p + 1)) : 16'h0;
        readWord(1'b0, 2'(p), w);
        chk("R5 packed result word", w, {hi, lo});
      end
      chk("R6 one DMA pulse", dmaP - m0, 1);
      chk("R10 irq pulses", irqP - i0, nIe);
    end

    // R3: no back-to-back, chain waits for a new trigger
    doSoft();
    cfgPri = mkCfg(4'd3, 8'h00, 8'h00, 8'h00);
    lenPri = 3'd1;
    r0 = reqP;
    pulsePri();
    waitCyc(30);
    chk("R3 holds after first segment", reqP - r0, 1);
    chk("R3 still busy in hold", busyPri, 1'b1);
    pulsePri();
    waitCyc(30);
    chk("R3 second segment on trigger", reqP - r0, 2);
    chk("R3 chain done", busyPri, 1'b0);
    chk("R3 hold trigger not overrun", ovrPri, 1'b0);

    // R6: DMA disabled
    dmaEnPri = 1'b0;
    cfgPri = mkCfg(4'd0, 8'hFF, 8'h00, 8'h00);
    lenPri = 3'd0;
    m0 = dmaP;
    pulsePri();
    waitCyc(20);
    chk("R6 disabled no DMA", dmaP - m0, 0);
    dmaEnPri = 1'b1;

    // R7: held DMA request cleared only by reading word 0
    dmaHold = 1'b1;
    lenPri = 3'd3;
    pulsePri();
    waitCyc(40);
    chk("R7 request held", dmaReqPri, 1'b1);
    @(negedge clk) begin rdEn = 1'b1; rdSec = 1'b0; rdPair = 2'd1; end
    @(negedge clk) rdEn = 1'b0;
    waitCyc(2);
    chk("R7 other word keeps request", dmaReqPri, 1'b1);
    @(negedge clk) begin rdEn = 1'b1; rdSec = 1'b1; rdPair = 2'd0; end
    @(negedge clk) rdEn = 1'b0;
    chk("R7 other chain keeps request", dmaReqPri, 1'b1);
    @(negedge clk) begin rdEn = 1'b1; rdSec = 1'b0; rdPair = 2'd0; end
    @(negedge clk) rdEn = 1'b0;
    chk("R7 word 0 read clears", dmaReqPri, 1'b0);
    dmaHold = 1'b0;

    // R8: overrun during a running chain
    doSoft();
    cfgPri = mkCfg(4'd4, 8'hFF, 8'h00, 8'h00);
    lenPri = 3'd3;
    r0 = reqP;
    pulsePri();
    waitCyc(2);
    pulsePri();
    waitCyc(60);
    chk("R8 overrun flagged", ovrPri, 1'b1);
    chk("R8 no restart", reqP - r0, 4);
    readWord(1'b0, 2'd1, w);
    chk("R8 results intact", w, {expRes(1'b0, 4'd7), expRes(1'b0, 4'd6)});
    pulsePri();
    waitCyc(60);
    chk("R8 flag sticky", ovrPri, 1'b1);

    // R4: sync mode
    doSoft();
    syncMode = 1'b1;
    cfgPri = mkCfg(4'd1, 8'hFF, 8'h00, 8'h00);
    cfgSec = mkCfg(4'd9, 8'hFF, 8'h00, 8'h00);
    lenPri = 3'd1;
    lenSec = 3'd1;
    r0 = reqP; s0 = reqS;
    pulseSec();
    waitCyc(30);
    chk("R4 own trigger ignored in sync", reqS - s0, 0);
    pulsePri();
    waitCyc(40);
    chk("R4 secondary request count", reqS - s0, 2);
    chk("R4 same start cycle", reqCycS[s0 % 1024], reqCycP[r0 % 1024]);
    readWord(1'b1, 2'd0, w);
    chk("R5 secondary packed word", w, {expRes(1'b1, 4'd10), expRes(1'b1, 4'd9)});
    syncMode = 1'b0;
    r0 = reqP; s0 = reqS;
    pulseSec();
    waitCyc(40);
    chk("R4 independent secondary runs", reqS - s0, 2);
    chk("R4 primary untouched", reqP - r0, 0);

    // R9: soft reset mid chain
    cfgPri = mkCfg(4'd2, 8'hFF, 8'h00, 8'h00);
    lenPri = 3'd7;
    pulsePri();
    waitCyc(3);
    pulsePri();
    waitCyc(3);
    @(negedge clk) softRst = 1'b1;
    waitCyc(2);
    chk("R9 idle and cleared", {busyPri, ovrPri, dmaReqPri}, 3'b000);
    r0 = reqP;
    trigPri = 1'b1;
    @(negedge clk) trigPri = 1'b0;
    waitCyc(2);
    readWord(1'b0, 2'd0, w);
    chk("R9 results cleared", w, '0);
    softRst = 1'b0;
    waitCyc(30);
    chk("R9 trigger ignored in reset", reqP - r0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule